// File: doc/BRIEF.md
# Locked Operand Exchange Unit

This block carries out the operand-swap micro-operation of a small CPU datapath. A decoded request arrives with an opcode byte, an addressing byte, an effective offset and the segment conditions for that offset. The block decides which form of exchange is meant and at what width. It then either trades the contents of two architectural registers in a single step, or swaps a register with a memory location through a locked read-then-write sequence on a simple memory port.

The unit holds the eight 32-bit general registers. A load port and a read port let the surrounding datapath fill and inspect them. Before it touches memory, the unit checks the effective offset against the segment rules. If a rule is broken it reports a fault vector and error code, and it changes neither registers nor memory. No condition flags are produced or altered.

Top module: `xchg_unit`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1 and `bus_lock`, `mem_req`, `done` and `fault_valid` are 0, and every register reads as 0.
- R2: Opcodes 0x90 to 0x97 swap register 0 with the register whose number is the opcode's low three bits. The width is 32 bits when `req_opsize32` is 1. Otherwise it is 16 bits, and the upper 16 bits of both registers are kept.
- R3: Opcodes 0x86 and 0x87 take the register number from addressing-byte bits 5:3 and the second operand from bits 2:0. A second operand with bits 7:6 equal to 3 is a register. 0x86 works on bytes: byte codes 0 to 3 name bits 7:0 of registers 0 to 3, and codes 4 to 7 name bits 15:8 of registers 0 to 3. Untouched bytes are kept. 0x87 uses 16 or 32 bits as in R2.
- R4: A register-register swap raises `done` for one cycle, in the first cycle after the request is accepted, with no memory access and with `bus_lock` low.
- R5: A memory-form swap first reads the operand at `req_ea`, then writes the register's value there, then loads the read value into the register. `mem_size` is 0 for byte, 1 for word and 2 for doubleword. Data is little-endian and right-aligned on `mem_rdata` and `mem_wdata`. Address, direction and size are held until `mem_ack`.
- R6: `bus_lock` is high in the cycle before the read and stays high through every cycle in which `mem_req` is high, for every memory-form swap. No prefix or privilege input affects it.
- R7: `bus_lock` falls in the cycle after the write is acknowledged. That same cycle carries the one-cycle `done` pulse.
- R8: In protected mode (`req_protected`=1), a memory-form swap whose segment is not writable faults with vector 13 and code 0. This check comes before the limit check.
- R9: In protected mode, a memory-form swap whose last byte offset (ea + size - 1) exceeds `req_seg_limit` faults with vector 12 if `req_seg_stack` is 1, and with vector 13 otherwise. A last byte equal to the limit does not fault.
- R10: In real-address mode, a memory-form swap whose last byte offset exceeds 0xFFFF faults with vector 13. A last byte of exactly 0xFFFF does not fault.
- R11: A faulting request raises `fault_valid` for one cycle, in the first cycle after acceptance. `fault_code` is 0 for every vector. No `mem_req`, no `bus_lock` and no `done` appear, and no register changes.
- R12: Any opcode outside 0x86, 0x87 and 0x90 to 0x97 faults with vector 6 and changes nothing.
- R13: `req_ready` is 1 only while the unit is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_opcode | input | 8 | Primary opcode byte |
| req_modrm | input | 8 | Addressing byte (register field, mode, second operand) |
| req_ea | input | AW | Effective offset of the memory operand |
| req_opsize32 | input | 1 | 1 selects 32-bit, 0 selects 16-bit wide operands |
| req_protected | input | 1 | 1 for protected mode, 0 for real-address mode |
| req_seg_writable | input | 1 | Segment of the memory operand allows writes |
| req_seg_stack | input | 1 | Memory operand lies in the stack segment |
| req_seg_limit | input | AW | Highest valid offset of the segment |
| done | output | 1 | One-cycle completion pulse |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_vector | output | 8 | Fault vector, valid with fault_valid |
| fault_code | output | CW | Error code, valid with fault_valid |
| bus_lock | output | 1 | Locked memory sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Memory byte address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned |
| mem_ack | input | 1 | Access complete |
| reg_wr_en | input | 1 | Load a full register |
| reg_wr_idx | input | log2(NREG) | Register to load |
| reg_wr_data | input | 32 | Value to load |
| reg_rd_idx | input | log2(NREG) | Register to inspect |
| reg_rd_data | output | 32 | Full value of inspected register |

## Verification
The bench sets up byte swaps where both operands share one physical register (low and high byte of register 0), to catch a write port that clobbers the other lane. It also covers high-byte codes paired with low-byte codes in different registers, which a flawed lane decode would route to registers 4 to 7. Memory operands are placed exactly at the segment or 0xFFFF boundary and one byte past it. An off-by-one in the last-byte calculation would then either fault a legal access or let an illegal one reach memory. The bench also confirms that a faulting request leaves the register and memory untouched, that a stack-limit violation reports 12 and not 13, and that the lock is released only together with completion.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

    localparam int XW = 32;
    localparam int XB = XW / 8;

    localparam logic [7:0]  VEC_UNDEF  = 8'd6;
    localparam logic [7:0]  VEC_STACK  = 8'd12;
    localparam logic [7:0]  VEC_PROT   = 8'd13;
    localparam logic [31:0] REAL_LIMIT = 32'h0000_FFFF;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_D = 2'd2
    } opsz_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_LOCK,
        ST_RD,
        ST_WR,
        ST_UPD
    } st_e;

    typedef struct packed {
        logic       legal;
        logic       is_mem;
        opsz_e      sz;
        logic [2:0] reg_a;
        logic [2:0] reg_b;
    } xop_t;

    typedef struct packed {
        logic       hit;
        logic [7:0] vec;
    } flt_t;

    function automatic logic [2:0] size_m1(opsz_e sz);
        case (sz)
            SZ_B:    return 3'd0;
            SZ_W:    return 3'd1;
            default: return 3'd3;
        endcase
    endfunction

    function automatic logic [XB-1:0] lane_mask(opsz_e sz, logic hi);
        case (sz)
            SZ_B:    return hi ? XB'(4'b0010) : XB'(4'b0001);
            SZ_W:    return XB'(4'b0011);
            default: return {XB{1'b1}};
        endcase
    endfunction

    function automatic logic [XW-1:0] lane_pick(logic [XW-1:0] w, opsz_e sz, logic hi);
        case (sz)
            SZ_B:    return hi ? {{(XW-8){1'b0}}, w[15:8]} : {{(XW-8){1'b0}}, w[7:0]};
            SZ_W:    return {{(XW-16){1'b0}}, w[15:0]};
            default: return w;
        endcase
    endfunction

    function automatic logic [XW-1:0] lane_merge(logic [XW-1:0] old, logic [XW-1:0] v,
                                                 opsz_e sz, logic hi);
        logic [XB-1:0] m;
        logic [XW-1:0] p;
        logic [XW-1:0] r;
        m = lane_mask(sz, hi);
        p = (sz == SZ_B && hi) ? (v << 8) : v;
        r = old;
        for (int i = 0; i < XB; i++) begin
            if (m[i]) r[8*i +: 8] = p[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/xchg_decode.sv
module xchg_decode
    import xchg_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] modrm,
    input  logic       opsize32,
    output xop_t       op
);

    opsz_e wide;

    always_comb begin
        wide = opsize32 ? SZ_D : SZ_W;
        op   = '0;
        if (opcode[7:3] == 5'b10010) begin
            // short form: accumulator against register in low bits
            op.legal  = 1'b1;
            op.is_mem = 1'b0;
            op.sz     = wide;
            op.reg_a  = 3'd0;
            op.reg_b  = opcode[2:0];
        end else if (opcode[7:1] == 7'b1000011) begin
            // addressing-byte form, bit 0 picks byte or wide
            op.legal  = 1'b1;
            op.is_mem = (modrm[7:6] != 2'b11);
            op.sz     = opcode[0] ? wide : SZ_B;
            op.reg_a  = modrm[5:3];
            op.reg_b  = modrm[2:0];
        end
    end

endmodule

// File: rtl/xchg_fault.sv
module xchg_fault
    import xchg_pkg::*;
#(
    parameter int AW = 32
) (
    input  opsz_e         sz,
    input  logic [AW-1:0] ea,
    input  logic          prot,
    input  logic          writable,
    input  logic          stack,
    input  logic [AW-1:0] limit,
    output flt_t          flt
);

    logic [AW:0]   last_off;
    logic [AW-1:0] eff_lim;
    logic          over;

    assign last_off = {1'b0, ea} + {{(AW-2){1'b0}}, size_m1(sz)};
    assign eff_lim  = prot ? limit : AW'(REAL_LIMIT);
    assign over     = last_off > {1'b0, eff_lim};

    always_comb begin
        flt = '0;
        if (prot && !writable) begin
            flt.hit = 1'b1;
            flt.vec = VEC_PROT;
        end else if (over) begin
            flt.hit = 1'b1;
            flt.vec = (prot && stack) ? VEC_STACK : VEC_PROT;
        end
    end

endmodule

// File: rtl/xchg_regfile.sv
module xchg_regfile
    import xchg_pkg::*;
#(
    parameter int NREG = 8,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ext_we,
    input  logic [IW-1:0] ext_widx,
    input  logic [XW-1:0] ext_wdata,
    input  logic [IW-1:0] ext_ridx,
    output logic [XW-1:0] ext_rdata,
    input  logic [IW-1:0] a_idx,
    input  logic [IW-1:0] b_idx,
    input  opsz_e         sz,
    output logic [XW-1:0] a_val,
    output logic [XW-1:0] b_val,
    input  logic          wa_en,
    input  logic [XW-1:0] wa_val,
    input  logic          wb_en,
    input  logic [XW-1:0] wb_val
);

    function automatic logic [IW-1:0] phys_of(logic [IW-1:0] idx, opsz_e s);
        return (s == SZ_B) ? {{(IW-2){1'b0}}, idx[1:0]} : idx;
    endfunction

    logic [XW-1:0] regs [NREG];
    logic [IW-1:0] pa, pb;
    logic          ha, hb;

    assign pa = phys_of(a_idx, sz);
    assign pb = phys_of(b_idx, sz);
    assign ha = (sz == SZ_B) && a_idx[2];
    assign hb = (sz == SZ_B) && b_idx[2];

    assign a_val     = lane_pick(regs[pa], sz, ha);
    assign b_val     = lane_pick(regs[pb], sz, hb);
    assign ext_rdata = regs[ext_ridx];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [XW-1:0] q;
        logic [XW-1:0] nxt;

        always_comb begin
            nxt = q;
            if (wa_en && pa == IW'(g)) nxt = lane_merge(nxt, wa_val, sz, ha);
            if (wb_en && pb == IW'(g)) nxt = lane_merge(nxt, wb_val, sz, hb);
        end

        always_ff @(posedge clk) begin
            if (rst)                                q <= '0;
            else if (ext_we && ext_widx == IW'(g))  q <= ext_wdata;
            else                                    q <= nxt;
        end

        assign regs[g] = q;
    end

endmodule

// File: rtl/xchg_unit.sv
module xchg_unit
    import xchg_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NREG = 8,
    parameter int CW   = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [7:0]    req_opcode,
    input  logic [7:0]    req_modrm,
    input  logic [AW-1:0] req_ea,
    input  logic          req_opsize32,
    input  logic          req_protected,
    input  logic          req_seg_writable,
    input  logic          req_seg_stack,
    input  logic [AW-1:0] req_seg_limit,
    output logic          done,
    output logic          fault_valid,
    output logic [7:0]    fault_vector,
    output logic [CW-1:0] fault_code,
    output logic          bus_lock,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [XW-1:0] mem_wdata,
    input  logic [XW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          reg_wr_en,
    input  logic [IW-1:0] reg_wr_idx,
    input  logic [XW-1:0] reg_wr_data,
    input  logic [IW-1:0] reg_rd_idx,
    output logic [XW-1:0] reg_rd_data
);

    st_e           st;
    logic [7:0]    q_opc, q_modrm;
    logic [AW-1:0] q_ea, q_lim;
    logic          q_os32, q_prot, q_wr, q_stk;
    logic [XW-1:0] q_rdat;

    xop_t          op;
    flt_t          flt;
    logic [XW-1:0] val_a, val_b;
    logic          exec_rr, exec_flt;

    xchg_decode u_dec (
        .opcode   (q_opc),
        .modrm    (q_modrm),
        .opsize32 (q_os32),
        .op       (op)
    );

    xchg_fault #(.AW(AW)) u_flt (
        .sz       (op.sz),
        .ea       (q_ea),
        .prot     (q_prot),
        .writable (q_wr),
        .stack    (q_stk),
        .limit    (q_lim),
        .flt      (flt)
    );

    assign exec_rr  = (st == ST_EXEC) && op.legal && !op.is_mem;
    assign exec_flt = (st == ST_EXEC) && (!op.legal || (op.is_mem && flt.hit));

    xchg_regfile #(.NREG(NREG)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .ext_we    (reg_wr_en),
        .ext_widx  (reg_wr_idx),
        .ext_wdata (reg_wr_data),
        .ext_ridx  (reg_rd_idx),
        .ext_rdata (reg_rd_data),
        .a_idx     (IW'(op.reg_a)),
        .b_idx     (IW'(op.reg_b)),
        .sz        (op.sz),
        .a_val     (val_a),
        .b_val     (val_b),
        .wa_en     (exec_rr || st == ST_UPD),
        .wa_val    ((st == ST_UPD) ? q_rdat : val_b),
        .wb_en     (exec_rr),
        .wb_val    (val_a)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            q_opc   <= '0;
            q_modrm <= '0;
            q_ea    <= '0;
            q_lim   <= '0;
            q_os32  <= 1'b0;
            q_prot  <= 1'b0;
            q_wr    <= 1'b0;
            q_stk   <= 1'b0;
            q_rdat  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    q_opc   <= req_opcode;
                    q_modrm <= req_modrm;
                    q_ea    <= req_ea;
                    q_lim   <= req_seg_limit;
                    q_os32  <= req_opsize32;
                    q_prot  <= req_protected;
                    q_wr    <= req_seg_writable;
                    q_stk   <= req_seg_stack;
                    st      <= ST_EXEC;
                end
                ST_EXEC: st <= (op.legal && op.is_mem && !flt.hit) ? ST_LOCK : ST_IDLE;
                ST_LOCK: st <= ST_RD;
                ST_RD: if (mem_ack) begin
                    q_rdat <= lane_pick(mem_rdata, op.sz, 1'b0);
                    st     <= ST_WR;
                end
                ST_WR:   if (mem_ack) st <= ST_UPD;
                ST_UPD:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = (st == ST_IDLE);
    assign bus_lock     = (st == ST_LOCK) || (st == ST_RD) || (st == ST_WR);
    assign mem_req      = (st == ST_RD) || (st == ST_WR);
    assign mem_we       = (st == ST_WR);
    assign mem_addr     = q_ea;
    assign mem_size     = op.sz;
    assign mem_wdata    = val_a;
    assign done         = exec_rr || (st == ST_UPD);
    assign fault_valid  = exec_flt;
    assign fault_vector = !exec_flt ? 8'd0 : (!op.legal ? VEC_UNDEF : flt.vec);
    assign fault_code   = '0;

endmodule

module xchg_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          done,
    input logic          fault_valid,
    input logic          bus_lock,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr
);

    // R6
    lock_cover_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> bus_lock);

    // R7
    lock_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_lock) |-> done);

    // R11
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (!mem_req && !bus_lock && !done));

    // R11
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault_valid |=> !fault_valid);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R13
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!bus_lock && !mem_req && !done));

    // R5
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind xchg_unit xchg_unit_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_ready   (req_ready),
    .done        (done),
    .fault_valid (fault_valid),
    .bus_lock    (bus_lock),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr)
);

// File: tb/xchg_unit_tb_top.sv
module xchg_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        req_valid = 1'b0, req_ready;
    logic [7:0]  req_opcode = '0, req_modrm = '0;
    logic [31:0] req_ea = '0, req_seg_limit = '0;
    logic        req_opsize32 = 1'b0, req_protected = 1'b0;
    logic        req_seg_writable = 1'b0, req_seg_stack = 1'b0;
    logic        done, fault_valid, bus_lock, mem_req, mem_we;
    logic [7:0]  fault_vector;
    logic [15:0] fault_code;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  mem_size;
    logic        mem_ack = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_idx = '0, reg_rd_idx = '0;
    logic [31:0] reg_wr_data = '0, reg_rd_data;

    xchg_unit dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_modrm(req_modrm), .req_ea(req_ea),
        .req_opsize32(req_opsize32), .req_protected(req_protected),
        .req_seg_writable(req_seg_writable), .req_seg_stack(req_seg_stack),
        .req_seg_limit(req_seg_limit),
        .done(done), .fault_valid(fault_valid), .fault_vector(fault_vector),
        .fault_code(fault_code), .bus_lock(bus_lock),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .reg_rd_idx(reg_rd_idx), .reg_rd_data(reg_rd_data)
    );

    int total = 0, bad = 0;
    int cyc = 0, acc_cyc = 0;
    int n_issued = 0, n_seen = 0;
    int memreq_cnt = 0;
    logic prev_lock = 1'b0;

    typedef struct {
        bit         fault;
        logic [7:0] vec;
        bit         rr;
        string      tag;
    } exp_t;
    exp_t sbq[$];
    exp_t cur;

    logic [7:0]  mem_model [256];
    int          wait_cnt = 0;
    int          nbytes;
    logic [31:0] rd_tmp;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // watchdog
    always @(posedge clk) begin
        if (cyc > WD_LIMIT) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog actual=hung expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // memory responder: acknowledges on the second edge of a request
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wait_cnt = 0;
        end else if (mem_req && !mem_ack) begin
            if (wait_cnt == 1) begin
                wait_cnt = 0;
                nbytes = (mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4;
                if (mem_we) begin
                    for (int i = 0; i < nbytes; i++)
                        mem_model[mem_addr[7:0] + 8'(i)] = mem_wdata[8*i +: 8];
                end else begin
                    rd_tmp = '0;
                    for (int i = 0; i < nbytes; i++)
                        rd_tmp[8*i +: 8] = mem_model[mem_addr[7:0] + 8'(i)];
                    mem_rdata <= rd_tmp;
                end
                mem_ack <= 1'b1;
            end else begin
                wait_cnt = wait_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req) begin
                memreq_cnt++;
                chk("R6 lock held during access", {31'b0, bus_lock}, 32'd1);
            end
            if (done || fault_valid) begin
                if (sbq.size() == 0) begin
                    chk("R11 unexpected completion", 32'd1, 32'd0);
                end else begin
                    cur = sbq.pop_front();
                    chk({cur.tag, " completion kind"}, {31'b0, fault_valid}, {31'b0, cur.fault});
                    if (cur.fault) begin
                        chk({cur.tag, " vector"}, {24'b0, fault_vector}, {24'b0, cur.vec});
                        chk("R11 error code", {16'b0, fault_code}, 32'd0);
                        chk("R11 single cycle", cyc - acc_cyc, 32'd1);
                    end else if (cur.rr) begin
                        chk("R4 swap latency", cyc - acc_cyc, 32'd1);
                        chk("R4 no lock", {31'b0, bus_lock}, 32'd0);
                    end else begin
                        chk("R7 lock before done", {31'b0, prev_lock}, 32'd1);
                        chk("R7 lock released at done", {31'b0, bus_lock}, 32'd0);
                    end
                end
                n_seen++;
            end
            prev_lock = bus_lock;
        end
    end

    task automatic load_reg(input int idx, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_idx  = 3'(idx);
        reg_wr_data = v;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic read_reg(input int idx, output logic [31:0] v);
        reg_rd_idx = 3'(idx);
        #1;
        v = reg_rd_data;
    endtask

    task automatic check_reg(input string tag, input int idx, input logic [31:0] exp);
        logic [31:0] v;
        read_reg(idx, v);
        chk(tag, v, exp);
    endtask

    task automatic check_mem(input string tag, input logic [7:0] a, input logic [7:0] exp);
        chk(tag, {24'b0, mem_model[a]}, {24'b0, exp});
    endtask

    task automatic run(input logic [7:0] opc, input logic [7:0] mrm, input logic [31:0] ea,
                       input bit os32, input bit prot, input bit wr, input bit stk,
                       input logic [31:0] lim, input bit is_fault, input logic [7:0] vec,
                       input bit rr, input string tag);
        exp_t e;
        e.fault = is_fault;
        e.vec   = vec;
        e.rr    = rr;
        e.tag   = tag;
        sbq.push_back(e);
        @(negedge clk);
        req_opcode       = opc;
        req_modrm        = mrm;
        req_ea           = ea;
        req_opsize32     = os32;
        req_protected    = prot;
        req_seg_writable = wr;
        req_seg_stack    = stk;
        req_seg_limit    = lim;
        req_valid        = 1'b1;
        @(posedge clk);
        acc_cyc = cyc;
        n_issued++;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R13 busy after accept", {31'b0, req_ready}, 32'd0);
        wait (n_seen == n_issued);
        @(negedge clk);
    endtask

    int mrq_before;

    initial begin
        for (int i = 0; i < 256; i++) mem_model[i] = 8'h00;
        mem_model[8'h40] = 8'h01; mem_model[8'h41] = 8'h02;
        mem_model[8'h42] = 8'h03; mem_model[8'h43] = 8'h04;
        mem_model[8'h80] = 8'hC3; mem_model[8'h81] = 8'h5A;
        mem_model[8'hFC] = 8'hAA; mem_model[8'hFD] = 8'hBB;
        mem_model[8'hFE] = 8'h10; mem_model[8'hFF] = 8'h20;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", {31'b0, req_ready}, 32'd1);
        chk("R1 lock", {31'b0, bus_lock}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1 done/fault", {30'b0, done, fault_valid}, 32'd0);
        check_reg("R1 reg clear", 3, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after release", {31'b0, req_ready}, 32'd1);

        load_reg(0, 32'h1122_3344);
        load_reg(1, 32'h5566_7788);
        load_reg(2, 32'h99AA_BBCC);
        load_reg(3, 32'hDDEE_FF00);
        load_reg(5, 32'h1234_5678);

        // R2 short form, 32-bit
        run(8'h91, 8'h00, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF, 0, 8'd0, 1, "R2 dword");
        check_reg("R2 eax", 0, 32'h5566_7788);
        check_reg("R2 ecx", 1, 32'h1122_3344);

        // R2 short form, 16-bit keeps upper halves
        run(8'h93, 8'h00, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, 32'hFFFF, 0, 8'd0, 1, "R2 word");
        check_reg("R2 ax half", 0, 32'h5566_FF00);
        check_reg("R2 bx half", 3, 32'hDDEE_7788);

        // R3 byte swap within one register (low vs high byte of reg 0)
        run(8'h86, 8'hC4, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF, 0, 8'd0, 1, "R3 same reg");
        check_reg("R3 lanes in reg0", 0, 32'h5566_00FF);

        // R3 low byte of reg1 with high byte of reg2
        run(8'h86, 8'hCE, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF, 0, 8'd0, 1, "R3 cross");
        check_reg("R3 reg1 low byte", 1, 32'h1122_33BB);
        check_reg("R3 reg2 high byte", 2, 32'h99AA_44CC);
        check_reg("R3 reg6 untouched", 6, 32'h0);

        // R5 dword memory swap
        run(8'h87, 8'h28, 32'h40, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF, 0, 8'd0, 0, "R5 dword mem");
        check_reg("R5 reg5 gets memory", 5, 32'h0403_0201);
        check_mem("R5 mem byte0", 8'h40, 8'h78);
        check_mem("R5 mem byte3", 8'h43, 8'h12);

        // R5 byte memory swap with a high-byte register
        run(8'h86, 8'h38, 32'h80, 1'b0, 1'b1, 1'b1, 1'b0, 32'hFFFF, 0, 8'd0, 0, "R5 byte mem");
        check_reg("R5 bh from memory", 3, 32'hDDEE_C388);
        check_mem("R5 byte written", 8'h80, 8'h77);
        check_mem("R5 neighbour kept", 8'h81, 8'h5A);

        // R10 real mode, last byte exactly 0xFFFF
        run(8'h87, 8'h08, 32'hFFFE, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 0, 8'd0, 0, "R10 edge ok");
        check_reg("R10 cx swapped", 1, 32'h1122_2010);
        check_mem("R10 mem lo", 8'hFE, 8'hBB);
        check_mem("R10 mem hi", 8'hFF, 8'h33);

        // R10 real mode, one byte past
        mrq_before = memreq_cnt;
        run(8'h87, 8'h08, 32'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0, 1, 8'd13, 0, "R10 over");
        check_reg("R11 reg kept after fault", 1, 32'h1122_2010);
        chk("R11 no memory access", memreq_cnt - mrq_before, 32'd0);
        check_mem("R11 mem kept", 8'hFF, 8'h33);

        // R8 non-writable segment
        mrq_before = memreq_cnt;
        run(8'h87, 8'h08, 32'h40, 1'b1, 1'b1, 1'b0, 1'b1, 32'hFFFF, 1, 8'd13, 0, "R8 readonly");
        chk("R8 no memory access", memreq_cnt - mrq_before, 32'd0);
        check_mem("R8 mem kept", 8'h40, 8'h78);

        // R9 stack limit overflow, then data segment overflow
        run(8'h87, 8'h08, 32'hFFD, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFFF, 1, 8'd12, 0, "R9 stack");
        run(8'h87, 8'h08, 32'hFFD, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFF, 1, 8'd13, 0, "R9 data");
        check_reg("R9 reg kept", 1, 32'h1122_2010);

        // R9 last byte equals limit: no fault
        run(8'h87, 8'h08, 32'hFFC, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFFF, 0, 8'd0, 0, "R9 at limit");
        check_reg("R9 ecx from memory", 1, 32'h33BB_BBAA);
        check_mem("R9 mem byte0", 8'hFC, 8'h10);
        check_mem("R9 mem byte3", 8'hFF, 8'h11);

        // R12 undefined opcode
        run(8'h88, 8'hC4, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 32'hFFFF, 1, 8'd6, 0, "R12 undef");
        check_reg("R12 reg0 kept", 0, 32'h5566_00FF);

        chk("R13 idle at end", {31'b0, req_ready}, 32'd1);
        chk("R1 scoreboard drained", sbq.size(), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule